// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between a set of interrupt sources and a processor core. Each source pulse sets a registered request flag belonging to one of ten vector slots. Several sources can share a slot, and those sources are ORed in front of the flag. Each slot carries a one-bit level select. Two slots can be raised to the top level, and the other eight can be raised to the middle level. Every other setting is the low level.

From the pending flags, a combinational picker chooses the slot with the highest level, and on a tie it chooses the lowest slot number. The picker only considers slots whose level is strictly above the level now in service. The chosen slot is latched and presented to the core as an interrupt request, a vector address and a level. That presentation stays frozen until the core acknowledges it.

An acknowledge marks the accepted level in a three-bit in-service set. A return strobe removes the highest marked level. The result is nested handling in which a request of equal or lower level waits.

Top module: `prio_vec_arbiter`

## Requirements
- R1: Slot k is presented at vector address 0x03 + 8*k, for k = 0 to 9.
- R2: `vec_lvl` uses the codes 1 = low, 2 = high and 3 = top. For slots 0 and 1, `lvl_sel[k]`=1 gives top and 0 gives low. For slots 2 to 9, `lvl_sel[k]`=1 gives high and 0 gives low.
- R3: Among pending eligible slots, the one with the highest level is presented.
- R4: Among eligible slots of equal level, the lowest slot number is presented.
- R5: A pending slot is presented only if its level is strictly above the highest level in service. An equal or lower request waits until the blocking levels are returned.
- R6: An acknowledge adds the presented level to the in-service set. `reti` removes only the highest level in that set, so the levels nest.
- R7: Once `irq` is high, `irq`, `vec_addr` and `vec_lvl` hold their values until `ack`, even if a higher request arrives in the meantime.
- R8: An acknowledge clears the accepted slot's flag only for slots marked in `AUTO_CLR`. By default these are all slots except 8 and 9. `clr_req[k]` clears flag k. A source pulse in the same cycle as a clear leaves the flag set.
- R9: Each source line sets the flag of the slot that `SRC_MAP` gives it. By default the sources map to slots 0,1,2,2,3,3,4,5,5,6,7,8,8,8,8,9,9,9 for sources 0 to 17.
- R10: After reset, `irq` is 0, `vec_lvl` is 0 and `vec_addr` is 0, all flags are clear and nothing is in service.
- R11: A source pulse sets its flag at the next clock edge, and `irq` rises at the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Source request pulses, merged per slot |
| lvl_sel | input | NUM_VEC | Per-slot level select |
| clr_req | input | NUM_VEC | Per-slot flag clear |
| ack | input | 1 | Core accepts the presented vector |
| reti | input | 1 | Core leaves the current handler |
| irq | output | 1 | Interrupt request to the core |
| vec_addr | output | ADDR_W | Address of the presented vector |
| vec_lvl | output | 2 | Level of the presented vector (0 when idle) |

## Verification
A wrong in-service set shows up at the ports as a missing or extra `irq` on the edge after a return strobe, which is two cycles after a blocked request was raised. A corrupted flag shows up as a vector that comes back after a return when it should not, or one that is lost when it should come back, within two clocks. A picker fault shows up as a wrong `vec_addr` or `vec_lvl` on the first cycle that `irq` is high. A latch that does not hold shows up as a change in address during the wait before `ack`.

// File: rtl/pva_pkg.sv
package pva_pkg;
   typedef logic [1:0] lvl_t;
   localparam lvl_t LVL_NONE = 2'd0;
   localparam lvl_t LVL_LOW  = 2'd1;
   localparam lvl_t LVL_HIGH = 2'd2;
   localparam lvl_t LVL_TOP  = 2'd3;
   localparam int   NUM_LVL  = 3;
endpackage

// File: rtl/pva_flags.sv
module pva_flags #(
   parameter int NUM_SRC = 18,
   parameter int NUM_VEC = 10,
   parameter int MAP_W   = 4,
   parameter logic [NUM_SRC*MAP_W-1:0] SRC_MAP = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic [NUM_VEC-1:0] clr,
   input  logic [NUM_VEC-1:0] ack_clr,
   output logic [NUM_VEC-1:0] flags
);
   for (genvar k = 0; k < NUM_VEC; k++) begin : g_slot
      logic hit;
      // OR of every source routed to this slot
      always_comb begin
         hit = 1'b0;
         for (int s = 0; s < NUM_SRC; s++)
            if (SRC_MAP[s*MAP_W +: MAP_W] == MAP_W'(k)) hit = hit | src[s];
      end
      // a new event outranks any clear in the same cycle
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) flags[k] <= 1'b0;
         else        flags[k] <= hit | (flags[k] & ~clr[k] & ~ack_clr[k]);
   end
endmodule

// File: rtl/pva_pick.sv
module pva_pick
   import pva_pkg::*;
#(
   parameter int NUM_VEC = 10,
   localparam int IDX_W  = $clog2(NUM_VEC)
) (
   input  logic [NUM_VEC-1:0] flags,
   input  lvl_t               slot_lvl [NUM_VEC],
   input  lvl_t               floor_lvl,
   output logic               found,
   output logic [IDX_W-1:0]   win_idx,
   output lvl_t               win_lvl
);
   // strict compare keeps the first (lowest) slot on a tie
   always_comb begin
      win_lvl = LVL_NONE;
      win_idx = '0;
      for (int k = 0; k < NUM_VEC; k++)
         if (flags[k] && slot_lvl[k] > floor_lvl && slot_lvl[k] > win_lvl) begin
            win_lvl = slot_lvl[k];
            win_idx = IDX_W'(k);
         end
      found = (win_lvl != LVL_NONE);
   end
endmodule

// File: rtl/pva_nest.sv
module pva_nest
   import pva_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  lvl_t               push_lvl,
   input  logic               pop,
   output logic [NUM_LVL-1:0] svc_set,
   output lvl_t               svc_lvl
);
   logic [NUM_LVL-1:0] nxt;
   logic               done;

   always_comb begin
      svc_lvl = LVL_NONE;
      for (int i = 0; i < NUM_LVL; i++)
         if (svc_set[i]) svc_lvl = lvl_t'(i + 1);
   end

   // pop removes the highest marked level first, then push adds one
   always_comb begin
      nxt  = svc_set;
      done = 1'b0;
      if (pop)
         for (int i = NUM_LVL - 1; i >= 0; i--)
            if (nxt[i] && !done) begin
               nxt[i] = 1'b0;
               done   = 1'b1;
            end
      if (push && push_lvl != LVL_NONE) nxt[int'(push_lvl) - 1] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) svc_set <= '0;
      else        svc_set <= nxt;
endmodule

// File: rtl/prio_vec_arbiter.sv
module prio_vec_arbiter
   import pva_pkg::*;
#(
   parameter int NUM_VEC    = 10,
   parameter int NUM_SRC    = 18,
   parameter int TOP_VECS   = 2,
   parameter int ADDR_W     = 8,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8,
   parameter int MAP_W      = 4,
   parameter logic [NUM_SRC*MAP_W-1:0] SRC_MAP = {
      4'd9, 4'd9, 4'd9, 4'd8, 4'd8, 4'd8, 4'd8, 4'd7, 4'd6,
      4'd5, 4'd5, 4'd4, 4'd3, 4'd3, 4'd2, 4'd2, 4'd1, 4'd0},
   parameter logic [NUM_VEC-1:0] AUTO_CLR = 10'b00_1111_1111,
   localparam int IDX_W = $clog2(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_VEC-1:0] lvl_sel,
   input  logic [NUM_VEC-1:0] clr_req,
   input  logic               ack,
   input  logic               reti,
   output logic               irq,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic [1:0]         vec_lvl
);
   if (TOP_VECS > NUM_VEC) begin : g_bad_top
      $error("TOP_VECS exceeds NUM_VEC");
   end
   if ((1 << MAP_W) < NUM_VEC) begin : g_bad_map
      $error("MAP_W too narrow for NUM_VEC");
   end
   if (VEC_BASE + VEC_STRIDE * (NUM_VEC - 1) >= (1 << ADDR_W)) begin : g_bad_addr
      $error("vector addresses overflow ADDR_W");
   end

   logic [NUM_VEC-1:0] flags, ack_clr;
   lvl_t               slot_lvl [NUM_VEC];
   logic               found;
   logic [IDX_W-1:0]   win_idx, pend_idx;
   lvl_t               win_lvl, pend_lvl, svc_lvl;
   logic [NUM_LVL-1:0] svc_set;
   logic               pend_v, take;

   // per-slot level decode: the first TOP_VECS slots reach the top level
   for (genvar k = 0; k < NUM_VEC; k++) begin : g_lvl
      if (k < TOP_VECS) begin : g_top
         assign slot_lvl[k] = lvl_sel[k] ? LVL_TOP : LVL_LOW;
      end else begin : g_mid
         assign slot_lvl[k] = lvl_sel[k] ? LVL_HIGH : LVL_LOW;
      end
   end

   assign take    = ack & pend_v;
   assign ack_clr = take ? (AUTO_CLR & (NUM_VEC'(1) << pend_idx)) : '0;

   pva_flags #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .MAP_W(MAP_W), .SRC_MAP(SRC_MAP))
   u_flags (.clk(clk), .rst_n(rst_n), .src(src_req), .clr(clr_req),
            .ack_clr(ack_clr), .flags(flags));

   pva_pick #(.NUM_VEC(NUM_VEC))
   u_pick (.flags(flags), .slot_lvl(slot_lvl), .floor_lvl(svc_lvl),
           .found(found), .win_idx(win_idx), .win_lvl(win_lvl));

   pva_nest u_nest (.clk(clk), .rst_n(rst_n), .push(take), .push_lvl(pend_lvl),
                    .pop(reti), .svc_set(svc_set), .svc_lvl(svc_lvl));

   // presentation latch: frozen from request until acknowledge
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         pend_v   <= 1'b0;
         pend_idx <= '0;
         pend_lvl <= LVL_NONE;
      end else if (take) begin
         pend_v   <= 1'b0;
      end else if (!pend_v && found) begin
         pend_v   <= 1'b1;
         pend_idx <= win_idx;
         pend_lvl <= win_lvl;
      end

   assign irq      = pend_v;
   assign vec_lvl  = pend_v ? pend_lvl : LVL_NONE;
   assign vec_addr = pend_v ? ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(pend_idx)
                            : '0;
endmodule

// File: rtl/prio_vec_arbiter_chk.sv
module prio_vec_arbiter_chk
   import pva_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8,
   parameter int TOP_VECS   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              ack,
   input logic              reti,
   input logic [ADDR_W-1:0] vec_addr,
   input logic [1:0]        vec_lvl,
   input logic [1:0]        svc_lvl
);
   localparam logic [ADDR_W-1:0] TOP_LIMIT = ADDR_W'(VEC_BASE + VEC_STRIDE * TOP_VECS);

   a_r1_addr_grid: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((vec_addr - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STRIDE)) == '0);

   a_r2_top_slots: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && vec_lvl == LVL_TOP) |-> vec_addr < TOP_LIMIT);

   a_r5_above_service: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> vec_lvl > svc_lvl);

   a_r6_push_level: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && ack && !reti) |=> svc_lvl == $past(vec_lvl));

   a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq && $stable(vec_addr) && $stable(vec_lvl));

   a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> vec_lvl == LVL_NONE);
endmodule

bind prio_vec_arbiter prio_vec_arbiter_chk #(
   .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .TOP_VECS(TOP_VECS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .ack(ack), .reti(reti),
   .vec_addr(vec_addr), .vec_lvl(vec_lvl), .svc_lvl(svc_lvl)
);

// File: tb/prio_vec_arbiter_tb_top.sv
module prio_vec_arbiter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 10;
   localparam int NS = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_req = '0;
   logic [NV-1:0] lvl_sel = '0;
   logic [NV-1:0] clr_req = '0;
   logic          ack = 1'b0;
   logic          reti = 1'b0;
   logic          irq;
   logic [7:0]    vec_addr;
   logic [1:0]    vec_lvl;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_vec_arbiter dut_i (.clk(clk), .rst_n(rst_n), .src_req(src_req), .lvl_sel(lvl_sel),
      .clr_req(clr_req), .ack(ack), .reti(reti), .irq(irq), .vec_addr(vec_addr),
      .vec_lvl(vec_lvl));

   // {sources, level selects, expected address, expected level}
   localparam logic [37:0] TBL [10] = '{
      {18'h00040, 10'h000, 8'h23, 2'd1},   // R1 R9 slot 4
      {18'h00008, 10'h000, 8'h13, 2'd1},   // R9 second source of slot 2
      {18'h10000, 10'h000, 8'h4B, 2'd1},   // R1 R9 slot 9
      {18'h00210, 10'h000, 8'h1B, 2'd1},   // R4 equal low levels
      {18'h00210, 10'h040, 8'h33, 2'd2},   // R3 high beats low
      {18'h00201, 10'h041, 8'h03, 2'd3},   // R2 R3 top beats high
      {18'h00006, 10'h002, 8'h0B, 2'd3},   // R2 slot 1 top
      {18'h00003, 10'h003, 8'h03, 2'd3},   // R4 top tie
      {18'h22000, 10'h200, 8'h4B, 2'd2},   // R3 slot 9 high
      {18'h01400, 10'h000, 8'h3B, 2'd1}    // R4 R9 low tie
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse(logic [NS-1:0] m);
      src_req = m; tick(); src_req = '0;
   endtask

   task automatic do_ack();
      ack = 1'b1; tick(); ack = 1'b0;
   endtask

   task automatic do_reti();
      reti = 1'b1; tick(); reti = 1'b0;
   endtask

   task automatic cleanup();
      clr_req = '1; tick(); clr_req = '0;
      reti = 1'b1; repeat (3) tick(); reti = 1'b0;
      tick();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      // R10 reset state
      chk("R10 irq", {7'd0, irq}, 8'd0);
      chk("R10 lvl", {6'd0, vec_lvl}, 8'd0);
      chk("R10 addr", vec_addr, 8'd0);
      rst_n = 1'b1;
      tick();

      // R11 latency: flag at edge one, irq at edge two
      pulse(18'h00040);
      chk("R11 early", {7'd0, irq}, 8'd0);
      tick();
      chk("R11 irq", {7'd0, irq}, 8'd1);
      do_ack(); cleanup();

      // table walk
      for (int i = 0; i < 10; i++) begin
         logic [37:0] e;
         e = TBL[i];
         lvl_sel = e[19:10];
         pulse(e[37:20]);
         tick();
         chk("R1-table irq", {7'd0, irq}, 8'd1);
         chk("R3/R4 table addr", vec_addr, e[9:2]);
         chk("R2 table lvl", {6'd0, vec_lvl}, {6'd0, e[1:0]});
         do_ack(); cleanup();
      end

      // R5 equal level waits for return
      lvl_sel = '0;
      pulse(18'h00010); tick();
      chk("R5 first", vec_addr, 8'h1B);
      do_ack();
      pulse(18'h00040); tick(); tick();
      chk("R5 blocked", {7'd0, irq}, 8'd0);
      do_reti(); tick();
      chk("R5 released", vec_addr, 8'h23);
      do_ack(); cleanup();

      // R6 nesting low -> high -> top, then unwinding
      pulse(18'h00010); tick(); do_ack();
      lvl_sel = 10'h041;
      pulse(18'h00200); tick();
      chk("R6 high nest", {6'd0, vec_lvl}, 8'd2);
      do_ack();
      pulse(18'h00001); tick();
      chk("R6 top nest", vec_addr, 8'h03);
      do_ack();
      lvl_sel = 10'h045;
      pulse(18'h00004); tick(); tick();
      chk("R6 blocked by top", {7'd0, irq}, 8'd0);
      do_reti(); tick();
      chk("R6 blocked by high", {7'd0, irq}, 8'd0);
      do_reti(); tick();
      chk("R6 after unwind", vec_addr, 8'h13);
      do_ack(); cleanup();

      // R7 hold while a higher request appears
      lvl_sel = 10'h001;
      pulse(18'h00400); tick();
      chk("R7 low shown", vec_addr, 8'h3B);
      pulse(18'h00001); tick(); tick();
      chk("R7 held addr", vec_addr, 8'h3B);
      chk("R7 held lvl", {6'd0, vec_lvl}, 8'd1);
      do_ack(); tick();
      chk("R7 preempt after ack", vec_addr, 8'h03);
      do_ack(); cleanup();

      // R8 manual-clear slot keeps its flag
      lvl_sel = '0;
      pulse(18'h00800); tick();
      chk("R8 slot8", vec_addr, 8'h43);
      do_ack(); do_reti(); tick();
      chk("R8 kept flag", vec_addr, 8'h43);
      do_ack();
      clr_req = 10'h100; tick(); clr_req = '0;
      do_reti(); tick(); tick();
      chk("R8 sw clear", {7'd0, irq}, 8'd0);
      // R8 auto-clear slot
      pulse(18'h00040); tick(); do_ack(); do_reti(); tick(); tick();
      chk("R8 auto clear", {7'd0, irq}, 8'd0);
      // R8 set beats clear
      src_req = 18'h00800; clr_req = 10'h100; tick();
      src_req = '0; clr_req = '0; tick();
      chk("R8 set wins", vec_addr, 8'h43);
      do_ack(); cleanup();

      // R10 reset mid-run drops a pending flag
      pulse(18'h00040);
      rst_n = 1'b0; tick(); rst_n = 1'b1; tick(); tick();
      chk("R10 flag dropped", {7'd0, irq}, 8'd0);

      finish_run();
   end
endmodule